// File: doc/BRIEF.md
# Transceiver Tx/Rx Reset Sequencer

This block brings up a serial transceiver whose internal transmit and receive elastic buffers are bypassed. In that mode the buffer resets have to be issued by fabric logic in a fixed order. After the system reset is released, the block issues a one-cycle transmit reset pulse. It then waits for the transceiver to report that the transmit reset has finished. Only after that does it issue a one-cycle receive reset pulse and wait for the matching completion flag.

The two completion inputs come from the transceiver's clock domain. Each passes through a two-flop synchronizer before the state machine uses it. A wait that lasts too long is handled by an optional, parameterised timeout. When the timeout expires, the block reissues the reset pulse that is still outstanding.

Two ready flags go to user logic: one for the transmit side and one for the receive side. Each flag rises only once its own completion has been seen. A flag stays high until the next system reset.

Top module: `xcvr_rst_seq`

## Requirements
- R1: In the first clock cycle after `sys_rst` is sampled low, `tx_rst_pulse` is high for exactly one cycle and every other output is low.
- R2: After the transmit pulse, the machine waits for `tx_done_in`. With `tx_done_in` driven high between two rising edges, `tx_ready` goes high after the third rising edge that follows. Two of those edges are synchronizer stages and one is the state update.
- R3: `rx_rst_pulse` is never high while `tx_ready` is low. `tx_ready` stays low until a synchronized `tx_done_in` has been seen.
- R4: `rx_rst_pulse` is high for exactly one cycle, in the same cycle that `tx_ready` first goes high.
- R5: After the receive pulse, `rx_ready` goes high on the third rising edge after `rx_done_in` is driven high. It never goes high before `tx_ready`.
- R6: With the timeout enabled, a transmit wait that sees no completion for TIMEOUT_CYC cycles reissues `tx_rst_pulse`. Without completion, the pulses repeat every TIMEOUT_CYC+1 cycles.
- R7: The same retry applies to the receive wait. `rx_rst_pulse` repeats every TIMEOUT_CYC+1 cycles while `tx_ready` stays high.
- R8: Once high, `tx_ready` and `rx_ready` stay high until `sys_rst`, even if both done inputs fall.
- R9: `sys_rst` is synchronous and active high. At any point in the sequence it clears all four outputs at the next rising edge, and the sequence restarts from R1 after release.
- R10: When a synchronized completion and the timeout expiry fall on the same edge, the completion wins and no retry pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| sys_rst | input | 1 | Synchronous active-high system reset |
| tx_done_in | input | 1 | Transmit reset completion from the transceiver (asynchronous) |
| rx_done_in | input | 1 | Receive reset completion from the transceiver (asynchronous) |
| tx_rst_pulse | output | 1 | Single-cycle transmit buffer reset |
| rx_rst_pulse | output | 1 | Single-cycle receive buffer reset |
| tx_ready | output | 1 | Transmit side may start |
| rx_ready | output | 1 | Receive side may start |

## Verification
A wrong state register shows up at the ports within one cycle. Every output is decoded directly from the state, so a stuck or skipped state gives a missing or doubled reset pulse, or a ready flag that rises too early or falls. An error in the synchronizer depth or the priority logic moves the ready edge by one or more cycles. The bench sweeps both completion latencies across the whole window up to the timeout boundary and compares every output on every cycle against an arithmetic timeline. A timer fault changes the retry period, and that shows up after the first expiry.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

   typedef enum logic [2:0] {
      SEQ_IDLE   = 3'd0,
      SEQ_TX_PUL = 3'd1,
      SEQ_TX_WT  = 3'd2,
      SEQ_RX_PUL = 3'd3,
      SEQ_RX_WT  = 3'd4,
      SEQ_UP     = 3'd5
   } seq_state_t;

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_async,
   output logic q_sync
);
   logic [STAGES-1:0] chain;

   generate
      genvar gi;
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain[0] <= 1'b0;
               else     chain[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain[gi] <= 1'b0;
               else     chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
   parameter int LIMIT  = 1024,
   parameter bit ENABLE = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic expired
);
   localparam int CNT_W = $clog2(LIMIT + 1);

   generate
      if (ENABLE) begin : g_on
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk) begin
            if (rst || !run) cnt <= '0;
            else             cnt <= cnt + 1'b1;
         end
         assign expired = run && (cnt == CNT_W'(LIMIT - 1));
      end else begin : g_off
         assign expired = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/xcvr_rst_seq.sv
module xcvr_rst_seq
   import rstseq_pkg::*;
#(
   parameter int TIMEOUT_CYC = 1024,
   parameter bit TIMEOUT_EN  = 1'b1,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic sys_rst,
   input  logic tx_done_in,
   input  logic rx_done_in,
   output logic tx_rst_pulse,
   output logic rx_rst_pulse,
   output logic tx_ready,
   output logic rx_ready
);
   initial begin
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
      assert (TIMEOUT_CYC >= 4) else $error("TIMEOUT_CYC must be at least 4");
   end

   seq_state_t st, st_nx;
   logic tx_done_s, rx_done_s;
   logic tx_exp, rx_exp;
   logic in_tx_wait, in_rx_wait;

   rstseq_sync #(.STAGES(SYNC_STAGES)) u_tx_sync (
      .clk(clk), .rst(sys_rst), .d_async(tx_done_in), .q_sync(tx_done_s));
   rstseq_sync #(.STAGES(SYNC_STAGES)) u_rx_sync (
      .clk(clk), .rst(sys_rst), .d_async(rx_done_in), .q_sync(rx_done_s));

   assign in_tx_wait = (st == SEQ_TX_WT);
   assign in_rx_wait = (st == SEQ_RX_WT);

   rstseq_timer #(.LIMIT(TIMEOUT_CYC), .ENABLE(TIMEOUT_EN)) u_tx_tmr (
      .clk(clk), .rst(sys_rst), .run(in_tx_wait), .expired(tx_exp));
   rstseq_timer #(.LIMIT(TIMEOUT_CYC), .ENABLE(TIMEOUT_EN)) u_rx_tmr (
      .clk(clk), .rst(sys_rst), .run(in_rx_wait), .expired(rx_exp));

   // completion takes priority over expiry in both waits
   always_comb begin
      st_nx = st;
      unique case (st)
         SEQ_IDLE:   st_nx = SEQ_TX_PUL;
         SEQ_TX_PUL: st_nx = SEQ_TX_WT;
         SEQ_TX_WT: begin
            if (tx_done_s)   st_nx = SEQ_RX_PUL;
            else if (tx_exp) st_nx = SEQ_TX_PUL;
         end
         SEQ_RX_PUL: st_nx = SEQ_RX_WT;
         SEQ_RX_WT: begin
            if (rx_done_s)   st_nx = SEQ_UP;
            else if (rx_exp) st_nx = SEQ_RX_PUL;
         end
         SEQ_UP:     st_nx = SEQ_UP;
         default:    st_nx = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (sys_rst) st <= SEQ_IDLE;
      else         st <= st_nx;
   end

   assign tx_rst_pulse = (st == SEQ_TX_PUL);
   assign rx_rst_pulse = (st == SEQ_RX_PUL);
   assign tx_ready     = (st == SEQ_RX_PUL) || (st == SEQ_RX_WT) || (st == SEQ_UP);
   assign rx_ready     = (st == SEQ_UP);
endmodule

// File: rtl/rstseq_checker.sv
module rstseq_checker (
   input logic clk,
   input logic sys_rst,
   input logic tx_done_in,
   input logic rx_done_in,
   input logic tx_rst_pulse,
   input logic rx_rst_pulse,
   input logic tx_ready,
   input logic rx_ready
);
   AST_TX_PULSE_SINGLE: assert property (@(posedge clk) disable iff (sys_rst)
      tx_rst_pulse |=> !tx_rst_pulse);                                  // R1
   AST_RX_NEEDS_TX: assert property (@(posedge clk) disable iff (sys_rst)
      rx_rst_pulse |-> tx_ready);                                       // R3
   AST_RX_PULSE_SINGLE: assert property (@(posedge clk) disable iff (sys_rst)
      rx_rst_pulse |=> !rx_rst_pulse);                                  // R4
   AST_RX_READY_ORDER: assert property (@(posedge clk) disable iff (sys_rst)
      rx_ready |-> tx_ready);                                           // R5
   AST_RX_READY_CAUSE: assert property (@(posedge clk) disable iff (sys_rst)
      $rose(rx_ready) |-> $past(rx_done_in));                           // R5
   AST_TX_READY_CAUSE: assert property (@(posedge clk) disable iff (sys_rst)
      $rose(tx_ready) |-> $past(tx_done_in));                           // R2
   AST_TX_READY_HOLD: assert property (@(posedge clk) disable iff (sys_rst)
      tx_ready |=> tx_ready);                                           // R8
   AST_RX_READY_HOLD: assert property (@(posedge clk) disable iff (sys_rst)
      rx_ready |=> rx_ready);                                           // R8
   AST_RESET_CLEARS: assert property (@(posedge clk)
      sys_rst |=> !(tx_rst_pulse || rx_rst_pulse || tx_ready || rx_ready)); // R9
   AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (sys_rst)
      !(tx_rst_pulse && rx_rst_pulse));                                 // R4
endmodule

bind xcvr_rst_seq rstseq_checker u_rstseq_checker (
   .clk(clk), .sys_rst(sys_rst), .tx_done_in(tx_done_in), .rx_done_in(rx_done_in),
   .tx_rst_pulse(tx_rst_pulse), .rx_rst_pulse(rx_rst_pulse),
   .tx_ready(tx_ready), .rx_ready(rx_ready));

// File: tb/xcvr_rst_seq_test.sv
`timescale 1ns/1ps
module xcvr_rst_seq_test;
   localparam int T = 8;

   logic clk = 1'b0;
   logic sys_rst = 1'b1;
   logic tx_done_in = 1'b0;
   logic rx_done_in = 1'b0;
   logic tx_rst_pulse, rx_rst_pulse, tx_ready, rx_ready;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   xcvr_rst_seq #(.TIMEOUT_CYC(T), .TIMEOUT_EN(1'b1), .SYNC_STAGES(2)) uut (
      .clk(clk), .sys_rst(sys_rst), .tx_done_in(tx_done_in), .rx_done_in(rx_done_in),
      .tx_rst_pulse(tx_rst_pulse), .rx_rst_pulse(rx_rst_pulse),
      .tx_ready(tx_ready), .rx_ready(rx_ready));

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s at t=%0t: actual %b expected %b", req, what, $time, act, exp);
      end
   endtask

   task automatic chk_all(input string req, input logic et, input logic er,
                          input logic etr, input logic err);
      chk(req, "tx_rst_pulse", tx_rst_pulse, et);
      chk(req, "rx_rst_pulse", rx_rst_pulse, er);
      chk(req, "tx_ready", tx_ready, etr);
      chk(req, "rx_ready", rx_ready, err);
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // hold reset for a few edges, check cleared outputs (R9), release at negedge
   task automatic start_seq;
      @(negedge clk);
      sys_rst = 1'b1; tx_done_in = 1'b0; rx_done_in = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk_all("R9", 1'b0, 1'b0, 1'b0, 1'b0);
      sys_rst = 1'b0;
   endtask

   // normal bring-up with completion latencies lt, lr (cycles in wait before raising)
   task automatic run_case(input int lt, input int lr);
      int tr, rr;
      tr = 5 + lt;
      rr = tr + 4 + lr;
      start_seq();
      for (int c = 1; c <= rr + 2; c++) begin
         @(posedge clk);
         @(negedge clk);
         chk_all((c < tr) ? "R2" : ((c == tr) ? "R4" : "R5"),
                 c == 1, c == tr, c >= tr, c >= rr);
         if (c == 2 + lt)  tx_done_in = 1'b1;
         if (c == tr + 1 + lr) rx_done_in = 1'b1;
      end
      // R8: completions fall, ready flags hold
      tx_done_in = 1'b0; rx_done_in = 1'b0;
      repeat (6) @(posedge clk);
      @(negedge clk);
      chk_all("R8", 1'b0, 1'b0, 1'b1, 1'b1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired: actual running expected finished");
      summary();
   end

   initial begin
      // R1..R5, R8, R10: sweep both latencies up to the expiry boundary (lt=T-3 is R10)
      for (int lt = 0; lt <= T - 3; lt++)
         for (int lr = 0; lr <= T - 3; lr++)
            run_case(lt, lr);

      // R6: no transmit completion, pulse every T+1 cycles
      start_seq();
      for (int c = 1; c <= 4 * (T + 1) + 2; c++) begin
         @(posedge clk);
         @(negedge clk);
         chk_all("R6", ((c - 1) % (T + 1)) == 0, 1'b0, 1'b0, 1'b0);
      end
      // late completion still finishes the transmit side
      tx_done_in = 1'b1;
      repeat (T + 4) @(posedge clk);
      @(negedge clk);
      chk("R6", "tx_ready after late done", tx_ready, 1'b1);

      // R7: transmit completes at once, receive never does
      start_seq();
      for (int c = 1; c <= 5 + 4 * (T + 1); c++) begin
         @(posedge clk);
         @(negedge clk);
         chk_all("R7", c == 1, (c >= 5) && (((c - 5) % (T + 1)) == 0), c >= 5, 1'b0);
         if (c == 2) tx_done_in = 1'b1;
      end

      // R9: reset during the receive wait clears everything after one edge
      @(negedge clk);
      sys_rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk_all("R9", 1'b0, 1'b0, 1'b0, 1'b0);
      tx_done_in = 1'b0;
      @(negedge clk);
      sys_rst = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk_all("R9", 1'b1, 1'b0, 1'b0, 1'b0);

      // restart cleanly after the mid-sequence reset
      run_case(1, 2);
      summary();
   end
endmodule